// File: doc/BRIEF.md
# Register Auto-Modify Tracking Log

This block keeps a short record of the general-register increments and decrements that the current instruction has made. After an abort, recovery software reads the record and undoes those register changes. The record is a 16-bit word that holds two 8-bit entries. Each entry pairs a 5-bit two's-complement delta with a 3-bit register number. Entries are stored in the order the updates arrive: the first in the low byte and the second in the high byte.

The instruction sequencer pulses a start strobe at the beginning of each instruction, which empties the record. Each register update arrives as a single event on a valid/ready stream. The stream never back-pressures: `upd_ready_o` is always high and an event is consumed in every cycle that `upd_valid_i` is high.

The abort logic raises a freeze level. While freeze is high, the record keeps its contents, so software can read it however long recovery takes. Implied stack pushes arrive as a delta of -2 on register 6, and implied pops arrive as +2 on register 6. For the block these are ordinary events, logged in arrival order.

Top module: `regmod_log`

## Requirements
- R1: Each logged entry is one byte. Bits 7:3 hold the low five bits of the update delta in two's complement (+2 is 00010, -2 is 11110), and bits 2:0 hold the register number.
- R2: The first logged update after a clear goes into `log_o[7:0]` and the second into `log_o[15:8]`. The record changes on the clock edge that accepts the event and is stable in cycles with no event and no start.
- R3: A start strobe while not frozen clears both bytes to zero. An update accepted in the same cycle becomes the first entry of the new record (low byte).
- R4: While `freeze_i` is high, update events and start strobes are ignored and `log_o` holds its value.
- R5: After `freeze_i` falls, the next start strobe clears the record and logging resumes normally.
- R6: A third and any further nonzero update within one instruction is ignored, and both stored bytes keep their values.
- R7: An update event whose delta byte is zero is not logged and does not use up an entry slot.
- R8: `upd_ready_o` is always high, and every cycle with `upd_valid_i` high is one event.
- R9: After reset `log_o` is zero and the record is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_start_i | input | 1 | Start-of-instruction strobe; clears the record |
| upd_valid_i | input | 1 | A register update event is present |
| upd_ready_o | output | 1 | Always 1; the block never stalls the stream |
| upd_reg_i | input | 3 | Register number of the update |
| upd_delta_i | input | 8 | Signed byte delta of the update |
| freeze_i | input | 1 | Abort freeze level; holds the record |
| log_o | output | 16 | Log word: high entry, low entry |

## Verification
Assertions check on every cycle that the slot count never goes past two and that the record stays stable while frozen. They also check that it stays stable when it is full, when nothing arrives, or when a zero delta arrives, and that a lone start empties it. Only the bench scenarios can show that the right entry lands in the right byte with the right encoding. The same goes for the ordering of a pop followed by a destination update, the case where a start and an update share a cycle, and logging resuming after the freeze is released.

// File: rtl/regmod_log_pkg.sv
package regmod_log_pkg;
  localparam int REG_W   = 3;
  localparam int DELTA_W = 5;
  localparam int IN_W    = 8;
  localparam int SLOTS   = 2;
  localparam int ENTRY_W = DELTA_W + REG_W;
endpackage

// File: rtl/regmod_entry_pack.sv
module regmod_entry_pack #(
  parameter int REG_W   = 3,
  parameter int DELTA_W = 5,
  parameter int IN_W    = 8
) (
  input  logic [REG_W-1:0]         reg_i,
  input  logic [IN_W-1:0]          delta_i,
  output logic [DELTA_W+REG_W-1:0] entry_o,
  output logic                     nonzero_o
);
  // delta field above, register number below
  assign entry_o   = {delta_i[DELTA_W-1:0], reg_i};
  assign nonzero_o = |delta_i;
endmodule

// File: rtl/regmod_slots.sv
module regmod_slots #(
  parameter int SLOTS   = 2,
  parameter int ENTRY_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     freeze_i,
  input  logic                     take_i,
  input  logic [ENTRY_W-1:0]       entry_i,
  output logic [SLOTS*ENTRY_W-1:0] log_o
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [ENTRY_W-1:0] slot_q [SLOTS];
  logic clr, acc;

  assign clr = start_i && !freeze_i;
  assign acc = take_i && !freeze_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (clr)                              cnt_q <= acc ? CNT_W'(1) : '0;
    else if (acc && cnt_q < CNT_W'(SLOTS))     cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q[g] <= '0;
      else if (clr)                            slot_q[g] <= (g == 0 && acc) ? entry_i : '0;
      else if (acc && cnt_q == CNT_W'(g))      slot_q[g] <= entry_i;
    end
    assign log_o[g*ENTRY_W +: ENTRY_W] = slot_q[g];
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOTS));
  p_full_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(SLOTS) && !start_i) |=> $stable(log_o));
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(log_o));
  p_clear_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !freeze_i && !take_i) |=> (log_o == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !take_i) |=> $stable(log_o));
endmodule

// File: rtl/regmod_log.sv
module regmod_log
  import regmod_log_pkg::*;
#(
  parameter int P_REG_W   = REG_W,
  parameter int P_DELTA_W = DELTA_W,
  parameter int P_IN_W    = IN_W,
  parameter int P_SLOTS   = SLOTS
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  instr_start_i,
  input  logic                                  upd_valid_i,
  output logic                                  upd_ready_o,
  input  logic [P_REG_W-1:0]                    upd_reg_i,
  input  logic [P_IN_W-1:0]                     upd_delta_i,
  input  logic                                  freeze_i,
  output logic [P_SLOTS*(P_DELTA_W+P_REG_W)-1:0] log_o
);
  localparam int EW = P_DELTA_W + P_REG_W;

  logic [EW-1:0] entry;
  logic          nonzero;

  assign upd_ready_o = 1'b1;

  regmod_entry_pack #(.REG_W(P_REG_W), .DELTA_W(P_DELTA_W), .IN_W(P_IN_W)) pack_i (
    .reg_i(upd_reg_i), .delta_i(upd_delta_i), .entry_o(entry), .nonzero_o(nonzero));

  regmod_slots #(.SLOTS(P_SLOTS), .ENTRY_W(EW)) slots_i (
    .clk(clk), .rst_n(rst_n), .start_i(instr_start_i), .freeze_i(freeze_i),
    .take_i(upd_valid_i && nonzero), .entry_i(entry), .log_o(log_o));

  p_zero_delta_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && upd_delta_i == '0 && !instr_start_i) |=> $stable(log_o));
endmodule

// File: tb/regmod_log_tb_top.sv
module regmod_log_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, freeze = 1'b0;
  logic [2:0] rnum = '0;
  logic [7:0] delta = '0;
  logic ready;
  logic [15:0] log_w;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_lo = '0, exp_hi = '0;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  regmod_log dut_i (
    .clk(clk), .rst_n(rst_n), .instr_start_i(start), .upd_valid_i(valid),
    .upd_ready_o(ready), .upd_reg_i(rnum), .upd_delta_i(delta),
    .freeze_i(freeze), .log_o(log_w));

  function automatic logic [7:0] enc(input logic [7:0] d, input logic [2:0] r);
    enc = {d[4:0], r};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: log actual %h expected %h", req, act, exp);
    end
  endtask

  // drive just after a falling edge, check at the next falling edge
  task automatic step(input logic st, input logic v, input logic fr,
                      input logic [2:0] r, input logic [7:0] d, input string req);
    start = st; valid = v; freeze = fr; rnum = r; delta = d;
    if (!fr) begin
      if (st) begin exp_lo = '0; exp_hi = '0; exp_cnt = 0; end
      if (v && d != 0) begin
        if (exp_cnt == 0) exp_lo = enc(d, r);
        else if (exp_cnt == 1) exp_hi = enc(d, r);
        if (exp_cnt < 2) exp_cnt++;
      end
    end
    @(negedge clk);
    check(req, log_w, {exp_hi, exp_lo});
    n_chk++;
    if (ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R8: ready actual %b expected 1", ready);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R9", log_w, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", log_w, 16'h0000);
    // R1 R2: pop then post-increment destination
    step(1, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 3'd6, 8'h02, "R1");
    check("R1", log_w, 16'h0016);
    step(0, 1, 0, 3'd3, 8'h02, "R2");
    check("R2", log_w, 16'h1316);
    // R6 third ignored
    step(0, 1, 0, 3'd5, 8'hFE, "R6");
    check("R6", log_w, 16'h1316);
    step(0, 0, 0, 0, 0, "R2");
    // R3 start with update in same cycle; -2 on r3
    step(1, 1, 0, 3'd3, 8'hFE, "R3");
    check("R3", log_w, 16'h00F3);
    // R7 zero delta not logged
    step(0, 1, 0, 3'd4, 8'h00, "R7");
    step(0, 1, 0, 3'd6, 8'hFE, "R7");
    check("R7", log_w, 16'hF6F3);
    // R4 freeze holds against start and updates
    step(0, 0, 1, 0, 0, "R4");
    step(1, 1, 1, 3'd2, 8'h02, "R4");
    step(1, 0, 1, 0, 0, "R4");
    check("R4", log_w, 16'hF6F3);
    // R5 resume
    step(0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 3'd1, 8'h01, "R5");
    check("R5", log_w, 16'h0009);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] d;
      int sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: d = 8'h02; 1: d = 8'hFE; 2: d = 8'h01;
        3: d = 8'hFF; 4: d = 8'h00; default: d = 8'($urandom);
      endcase
      step($urandom_range(0, 5) == 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 9) == 0, 3'($urandom), d, "R2");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule